// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a watchdog timer on a small register port: address, write enable, write data, read enable and read data. All of these are synchronous to one peripheral clock. Software sets the period, turns the timer on, and must then write a fixed key to a restart register before the countdown reaches zero. If it does not, the timer takes one of two actions. In direct mode it drives a system reset pulse whose length is set by an encoded field. In interrupt mode it first raises an interrupt and gives software one more full period to acknowledge it. Only if that second period also runs out does it drive the reset pulse.

The period is a power of two. The select field `sel` picks 2^(BASE_EXP+sel) cycles, and BASE_EXP defaults to 16. Once the enable bit is set, software cannot clear it. The live count can be read back at any time.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, every register reads 0 except the count, which reads 2^BASE_EXP-1. `irq_o` and `sys_rst_o` are low. While the timer is disabled, the count follows the reload value and no response is ever produced.
- R2: Control register, address 0: bit 0 is enable, bit 1 is the mode (0 = direct reset, 1 = interrupt first), and bits 4:2 are the pulse-length code. Once enable reads 1, no write can return it to 0.
- R3: In direct mode, an expiry makes `sys_rst_o` rise in the cycle after the count reads 0.
- R4: In interrupt mode, the first expiry sets the interrupt flag. `irq_o` then rises one cycle later, the count reloads, and no reset pulse is generated.
- R5: A write to address 2 whose bits 7:0 equal 0x76 reloads the count on the next edge. This has priority over an expiry in the same cycle.
- R6: A write to address 2 with any other value in bits 7:0 leaves the countdown untouched.
- R7: The reset pulse lasts 2^(code+1) cycles, where code is the pulse-length field. This gives 2 cycles for code 0 and 256 cycles for code 7.
- R8: Period-select register, address 1, bits 3:0 (`sel`): the count reloads to 2^(BASE_EXP+sel)-1 and decreases by one each enabled cycle. It expires when it reaches 0, so the period is 2^(BASE_EXP+sel) cycles.
- R9: Reading address 4 returns the interrupt flag in bit 0. A read (`rd_en_i`) of address 5 clears the flag on the next edge.
- R10: In interrupt mode, an expiry while the flag is still set produces the reset pulse.
- R11: A new `sel` written while the timer runs does not change the current countdown. It takes effect at the next reload, whether that reload comes from a key write or from an expiry.
- R12: Address 3 reads the live count. Addresses 0 to 5 are combinational reads, and all other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register word address |
| wr_en_i | input | 1 | Write strobe, one cycle |
| rd_en_i | input | 1 | Read strobe; only its side effect on address 5 matters |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i`, same cycle |
| irq_o | output | 1 | Interrupt flag level |
| sys_rst_o | output | 1 | System reset pulse, active high |

## Verification
A write or a key takes effect on the clock edge that samples it. Read data is combinational, so the new value of a register shows on `rd_data_o` in the same cycle as the address. `sys_rst_o` and `irq_o` rise one edge after the edge on which the count reads 0, and the reset pulse then counts down one cycle per edge. The bench advances a behavioural model on each rising edge, using the same inputs the design sampled. At each falling edge it compares the read data, the interrupt and the reset outputs, so every latency listed here is checked exactly in every cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_SEL  = 3'd1,
    A_KICK = 3'd2,
    A_CNT  = 3'd3,
    A_STAT = 3'd4,
    A_EOI  = 3'd5
  } wd_addr_e;

  localparam logic [7:0] KICK_KEY = 8'h76;

  typedef struct packed {
    logic [2:0] plen;
    logic       irq_mode;
    logic       en;
  } wd_ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       addr_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [31:0]      wr_data_i,
  output wd_ctrl_t         ctrl_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             kick_o,
  output logic             eoi_o
);
  wd_ctrl_t         ctrl_q;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      sel_q  <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_CTRL) begin
        ctrl_q.en       <= ctrl_q.en | wr_data_i[0]; // sticky
        ctrl_q.irq_mode <= wr_data_i[1];
        ctrl_q.plen     <= wr_data_i[4:2];
      end
      if (addr_i == A_SEL) sel_q <= wr_data_i[SEL_W-1:0];
    end
  end

  assign ctrl_o = ctrl_q;
  assign sel_o  = sel_q;
  assign kick_o = wr_en_i && (addr_i == A_KICK) && (wr_data_i[7:0] == KICK_KEY);
  assign eoi_o  = rd_en_i && (addr_i == A_EOI);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int BASE_EXP = 16,
  parameter int SEL_W    = 4,
  parameter int CNT_W    = BASE_EXP + (1 << SEL_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             kick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             expire_o
);
  localparam logic [CNT_W:0]   ONE       = (CNT_W+1)'(1);
  localparam logic [CNT_W-1:0] RST_COUNT = CNT_W'((ONE << BASE_EXP) - ONE);

  logic [CNT_W:0]   pow2;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    pow2     = ONE << (BASE_EXP + int'(sel_i));
    reload_o = pow2[CNT_W-1:0] - CNT_W'(1); // wraps to all ones at top select
  end

  assign expire_o = en_i && (cnt_q == '0) && !kick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= RST_COUNT;
    else if (!en_i || kick_i || expire_o) cnt_q <= reload_o;
    else                                  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdog_resp.sv
module wdog_resp #(
  parameter int PLEN_W  = 3,
  parameter int PULSE_W = (1 << PLEN_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              expire_i,
  input  logic              irq_mode_i,
  input  logic [PLEN_W-1:0] plen_i,
  input  logic              eoi_i,
  output logic              flag_o,
  output logic              rst_o,
  output logic [PULSE_W-1:0] pulse_cnt_o
);
  logic               flag_q;
  logic               fire;
  logic [PULSE_W-1:0] pcnt_q;

  assign fire = expire_i && (!irq_mode_i || flag_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 flag_q <= 1'b0;
    else if (expire_i && irq_mode_i && !flag_q)  flag_q <= 1'b1;
    else if (eoi_i)                              flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pcnt_q <= '0;
    else if (fire)           pcnt_q <= PULSE_W'(2) << plen_i;
    else if (pcnt_q != '0)   pcnt_q <= pcnt_q - PULSE_W'(1);
  end

  assign flag_o      = flag_q;
  assign rst_o       = (pcnt_q != '0);
  assign pulse_cnt_o = pcnt_q;
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int BASE_EXP = 16,
  parameter int SEL_W    = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  addr_i,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        irq_o,
  output logic        sys_rst_o
);
  localparam int CNT_W   = BASE_EXP + (1 << SEL_W) - 1;
  localparam int PLEN_W  = 3;
  localparam int PULSE_W = (1 << PLEN_W) + 1;

  wd_ctrl_t           ctrl;
  logic [SEL_W-1:0]   sel;
  logic               kick, eoi, expire, flag;
  logic [CNT_W-1:0]   cnt, reload;
  logic [PULSE_W-1:0] pulse_cnt;

  wdog_regs #(.SEL_W(SEL_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .rd_en_i, .wr_data_i,
    .ctrl_o(ctrl), .sel_o(sel), .kick_o(kick), .eoi_o(eoi)
  );

  wdog_counter #(.BASE_EXP(BASE_EXP), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .en_i(ctrl.en), .sel_i(sel), .kick_i(kick),
    .cnt_o(cnt), .reload_o(reload), .expire_o(expire)
  );

  wdog_resp #(.PLEN_W(PLEN_W), .PULSE_W(PULSE_W)) u_resp (
    .clk_i, .rst_ni, .expire_i(expire), .irq_mode_i(ctrl.irq_mode),
    .plen_i(ctrl.plen), .eoi_i(eoi), .flag_o(flag), .rst_o(sys_rst_o),
    .pulse_cnt_o(pulse_cnt)
  );

  always_comb begin
    rd_data_o = '0;
    case (addr_i)
      A_CTRL:  rd_data_o = 32'(ctrl);
      A_SEL:   rd_data_o = 32'(sel);
      A_CNT:   rd_data_o = 32'(cnt);
      A_STAT:  rd_data_o = 32'(flag);
      default: rd_data_o = '0;
    endcase
  end

  assign irq_o = flag;
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk
  import wdog_pkg::*;
#(
  parameter int CNT_W   = 31,
  parameter int PULSE_W = 9
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [2:0]         addr_i,
  input logic               wr_en_i,
  input logic [31:0]        wr_data_i,
  input logic               en,
  input logic               irq_mode,
  input logic               expire,
  input logic               kick,
  input logic [CNT_W-1:0]   cnt,
  input logic [CNT_W-1:0]   reload,
  input logic [PULSE_W-1:0] pulse_cnt,
  input logic               irq_o,
  input logic               sys_rst_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !sys_rst_o && !irq_o); // R1
  AST_EN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en |=> en); // R2
  AST_DIRECT_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire && !irq_mode |=> sys_rst_o); // R3
  AST_IRQ_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire && irq_mode && !irq_o |=> irq_o); // R4
  AST_KEY_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick |=> cnt == $past(reload)); // R5
  AST_BAD_KEY_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == A_KICK && wr_data_i[7:0] != KICK_KEY && en && cnt != '0
    |=> cnt == $past(cnt) - CNT_W'(1)); // R6
  AST_PULSE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_cnt <= PULSE_W'(256)); // R7
endmodule

bind wdog_keyed wdog_keyed_chk #(.CNT_W(CNT_W), .PULSE_W(PULSE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wr_data_i(wr_data_i), .en(ctrl.en), .irq_mode(ctrl.irq_mode),
  .expire(expire), .kick(kick), .cnt(cnt), .reload(reload),
  .pulse_cnt(pulse_cnt), .irq_o(irq_o), .sys_rst_o(sys_rst_o)
);

// File: tb/tb_wdog_keyed.sv
`timescale 1ns/1ps
module tb_wdog_keyed;
  localparam int BASE = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = 3'd3;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic        irq, srst;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  // model state
  int m_en, m_mode, m_len, m_sel, m_cnt, m_flag, m_pulse;

  always #4 clk = ~clk;

  wdog_keyed #(.BASE_EXP(BASE), .SEL_W(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .wr_data_i(wdata), .rd_data_o(rd_data),
    .irq_o(irq), .sys_rst_o(srst)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_mode = 0; m_len = 0; m_sel = 0;
      m_cnt = 2**BASE - 1; m_flag = 0; m_pulse = 0;
    end else begin
      automatic int reload = 2**(BASE + m_sel) - 1;
      automatic bit kick = wr_en && addr == 3'd2 && wdata[7:0] == 8'h76;
      automatic bit expire = m_en != 0 && m_cnt == 0 && !kick;
      automatic bit fire = expire && (m_mode == 0 || m_flag != 0);
      if (m_en == 0 || kick || expire) m_cnt = reload;
      else m_cnt = m_cnt - 1;
      if (fire) m_pulse = 2**(m_len + 1);
      else if (m_pulse > 0) m_pulse = m_pulse - 1;
      if (expire && m_mode != 0 && m_flag == 0) m_flag = 1;
      else if (rd_en && addr == 3'd5) m_flag = 0;
      if (wr_en && addr == 3'd0) begin
        if (wdata[0]) m_en = 1;
        m_mode = int'(wdata[1]);
        m_len = int'(wdata[4:2]);
      end
      if (wr_en && addr == 3'd1) m_sel = int'(wdata[3:0]);
    end
  end

  function automatic logic [31:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return 32'(m_en + 2*m_mode + 4*m_len);
      3'd1: return 32'(m_sel);
      3'd3: return 32'(m_cnt);
      3'd4: return 32'(m_flag);
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("rd_data", rd_data, exp_rd(addr));
      check("irq_o", 32'(irq), 32'(m_flag != 0));
      check("sys_rst_o", 32'(srst), 32'(m_pulse > 0));
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); #1;
    addr = a; wr_en = 1'b1; wdata = d;
    @(negedge clk); #1;
    wr_en = 1'b0; addr = 3'd3; wdata = '0;
  endtask

  task automatic rd(logic [2:0] a);
    @(negedge clk); #1;
    addr = a; rd_en = 1'b1;
    @(negedge clk); #1;
    rd_en = 1'b0; addr = 3'd3;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    cur_req = "R1"; idle(5); rd(3'd0); rd(3'd1); rd(3'd4);
    cur_req = "R12"; wr(3'd1, 32'd1); rd(3'd1); idle(3);
    // R8 / R3: direct mode, shortest pulse, period 16
    cur_req = "R3"; wr(3'd0, 32'h1); idle(40);
    cur_req = "R6"; wr(3'd2, 32'h75); wr(3'd2, 32'h176 ^ 32'h1); idle(4);
    cur_req = "R5"; wr(3'd2, 32'h76); idle(6); wr(3'd2, 32'hAB76); idle(20);
    cur_req = "R2"; wr(3'd0, 32'h0); rd(3'd0); idle(20);
    // R7: longest pulse, direct
    cur_req = "R7"; wr(3'd0, 32'h1C); idle(300);
    // R4 / R10: interrupt first, then reset on second expiry
    cur_req = "R4"; wr(3'd0, 32'h2 | (32'd1 << 2)); wr(3'd2, 32'h76); idle(18);
    cur_req = "R9"; rd(3'd4); idle(2);
    cur_req = "R10"; idle(30);
    cur_req = "R9"; rd(3'd5); rd(3'd4); idle(12); rd(3'd5); idle(10); rd(3'd5);
    // R11: new select applies only at next reload
    cur_req = "R11"; wr(3'd2, 32'h76); idle(3); wr(3'd1, 32'd2); idle(8);
    rd(3'd5); idle(40); rd(3'd5); wr(3'd2, 32'h76); idle(20);
    cur_req = "R8"; wr(3'd1, 32'd0); wr(3'd0, 32'h0); idle(40);
    cur_req = "R12"; rd(3'd6); rd(3'd7); idle(2);
    done = 1;
    summary();
  end
endmodule